// File: doc/BRIEF.md
# Double-Edge IQ Sample Capture and Word Packer

This block takes complex baseband samples from an external receiver that sends a clock along with its data. There are four data lines, two for the in-phase channel and two for the quadrature channel, and a bit arrives on each of them at both edges of that clock. The block samples the lines only with that clock, on its rising and its falling edge. It joins the two half-cycle captures into one 4-bit I value and one 4-bit Q value for every clock cycle. All logic in the block runs on the forwarded clock.

Complete pairs are gathered four at a time into 32-bit words. The words pass through a small FIFO to a valid/ready stream output in the style of AXI4-Stream. The FIFO keeps taking words while the consumer stalls for a short time. A capture enable starts packing at a word boundary. When the enable is dropped, a partly filled word is padded with zeros and sent out marked as the last word. Words that find the FIFO full are lost, and a sticky flag records that loss until software clears it.

Top module: `iqcap_ddr_packer`

## Requirements
- R1: A synchronous active-high reset empties the FIFO (`m_tvalid` low), clears `ovf_flag` and returns packing to byte slot 0, and this holds even while the FIFO is holding words.
- R2: `rx_i[1:0]` and `rx_q[1:0]` sampled at a rising edge become bits [3:2] of I and Q. The values on the same lines at the following falling edge become bits [1:0].
- R3: Within a word, the pair accepted first occupies bits [7:0] and later pairs fill the higher bytes in order. Each byte is laid out as {I[3:0], Q[3:0]}.
- R4: After four accepted pairs, a full word is sent with `m_tlast` = 0.
- R5: `cap_en` is examined once per clock cycle for the pair that is complete at that moment. Pairs seen while it is low are discarded, and packing resumes at byte slot 0 once it rises again.
- R6: If `cap_en` is low while a word holds 1 to 3 pairs, that word is sent with zeros in its empty bytes and `m_tlast` = 1. If no pairs are pending, no word is sent.
- R7: The output FIFO holds 16 words in arrival order. While `m_tvalid` is high and `m_tready` is low, `m_tvalid`, `m_tdata` and `m_tlast` do not change. At a 75% ready rate, no word is lost.
- R8: A word that completes while the FIFO is full is discarded and `ovf_flag` is set. The words already in the FIFO are delivered unchanged.
- R9: `ovf_flag` stays set until a cycle with `ovf_clr` high, which clears it. A new overflow in the same cycle as the clear takes priority and leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock forwarded by the receiver at the sample rate |
| rst | input | 1 | Synchronous active-high reset |
| cap_en | input | 1 | Capture enable, checked every cycle |
| rx_i | input | 2 | I data lines, double data rate |
| rx_q | input | 2 | Q data lines, double data rate |
| ovf_clr | input | 1 | Pulse high to clear the overflow flag |
| m_tvalid | output | 1 | Stream word valid |
| m_tready | input | 1 | Stream consumer ready |
| m_tdata | output | 32 | Four packed IQ pairs, oldest pair in the low byte |
| m_tlast | output | 1 | Marks a zero-padded final word after capture stops |
| ovf_flag | output | 1 | Sticky flag: a word was lost because the FIFO was full |

## Verification
The bench uses the default FIFO depth of 16. Holding ready low therefore fills the FIFO after 16 words, and the overflow path and its sticky flag are reached within a few hundred cycles. The 4-bit sample width makes the pair space only 256 values. Every one of them goes through the double-edge capture and the byte packing, while ready follows a pseudo-random pattern. Runs of enable with every length from 1 to 7, and a repeating gap pattern, cover the flush at each partial fill and the restart at slot 0.

// File: rtl/iqcap_pkg.sv
package iqcap_pkg;

    localparam int HALF_W         = 2;
    localparam int SAMP_W         = 2 * HALF_W;
    localparam int PAIR_W         = 2 * SAMP_W;
    localparam int PAIRS_PER_WORD = 4;
    localparam int WORD_W         = PAIR_W * PAIRS_PER_WORD;
    localparam int SLOT_W         = $clog2(PAIRS_PER_WORD);

    typedef struct packed {
        logic [SAMP_W-1:0] i;
        logic [SAMP_W-1:0] q;
    } iq_pair_t;

    typedef struct packed {
        logic              last;
        logic [WORD_W-1:0] data;
    } stream_word_t;

    // Early (rising-edge) halves are the upper bits of each sample.
    function automatic iq_pair_t join_halves(
        input logic [HALF_W-1:0] early_i,
        input logic [HALF_W-1:0] early_q,
        input logic [HALF_W-1:0] late_i,
        input logic [HALF_W-1:0] late_q
    );
        iq_pair_t p;
        p.i = {early_i, late_i};
        p.q = {early_q, late_q};
        return p;
    endfunction

    function automatic logic [WORD_W-1:0] place_pair(
        input logic [WORD_W-1:0] acc,
        input iq_pair_t          p,
        input logic [SLOT_W-1:0] slot
    );
        logic [WORD_W-1:0] widened;
        widened = {{(WORD_W-PAIR_W){1'b0}}, p};
        return acc | (widened << (PAIR_W * int'(slot)));
    endfunction

endpackage

// File: rtl/iqcap_ddr_front.sv
module iqcap_ddr_front
    import iqcap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [HALF_W-1:0] rx_i,
    input  logic [HALF_W-1:0] rx_q,
    output iq_pair_t          pair,
    output logic              pair_vld
);

    logic [HALF_W-1:0] rise_i, rise_q;
    logic [HALF_W-1:0] fall_i, fall_q;
    logic              primed;

    // Rising-edge capture: upper half of the current sample.
    always_ff @(posedge clk) begin
        rise_i <= rx_i;
        rise_q <= rx_q;
    end

    // Falling-edge capture: lower half, taken mid-cycle.
    always_ff @(negedge clk) begin
        fall_i <= rx_i;
        fall_q <= rx_q;
    end

    // Join the halves from the previous cycle at the next rising edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            primed   <= 1'b0;
            pair_vld <= 1'b0;
            pair     <= '0;
        end else begin
            primed   <= 1'b1;
            pair_vld <= primed;
            pair     <= join_halves(rise_i, rise_q, fall_i, fall_q);
        end
    end

    p_pair_steady_r2: assert property (@(posedge clk) disable iff (rst)
        pair_vld |=> pair_vld);

endmodule

// File: rtl/iqcap_packer.sv
module iqcap_packer
    import iqcap_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  iq_pair_t     pair,
    input  logic         pair_vld,
    output logic         word_vld,
    output stream_word_t word
);

    logic [SLOT_W-1:0] slot;
    logic [WORD_W-1:0] acc;
    logic [WORD_W-1:0] placed;
    logic              take;
    logic              at_end;
    logic              flush;

    always_comb begin
        take   = en && pair_vld;
        placed = place_pair(acc, pair, slot);
        at_end = (slot == SLOT_W'(PAIRS_PER_WORD - 1));
        flush  = !en && (slot != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot     <= '0;
            acc      <= '0;
            word_vld <= 1'b0;
            word     <= '0;
        end else begin
            word_vld <= 1'b0;
            if (take) begin
                if (at_end) begin
                    word_vld  <= 1'b1;
                    word.data <= placed;
                    word.last <= 1'b0;
                    acc       <= '0;
                    slot      <= '0;
                end else begin
                    acc  <= placed;
                    slot <= slot + 1'b1;
                end
            end else if (flush) begin
                word_vld  <= 1'b1;
                word.data <= acc;
                word.last <= 1'b1;
                acc       <= '0;
                slot      <= '0;
            end
        end
    end

    p_idle_slot_r5: assert property (@(posedge clk) disable iff (rst)
        !en |=> (slot == '0));

    p_flush_last_r6: assert property (@(posedge clk) disable iff (rst)
        (word_vld && word.last) |-> !$past(en));

    p_full_word_r4: assert property (@(posedge clk) disable iff (rst)
        (word_vld && !word.last) |-> ($past(en) && $past(slot) == SLOT_W'(PAIRS_PER_WORD - 1)));

endmodule

// File: rtl/iqcap_fifo.sv
module iqcap_fifo
    import iqcap_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  stream_word_t      in_word,
    input  logic              ovf_clr,
    output logic              tvalid,
    input  logic              tready,
    output logic [WORD_W-1:0] tdata,
    output logic              tlast,
    output logic              ovf
);

    localparam int AW = $clog2(DEPTH);

    stream_word_t      mem [DEPTH];
    logic [AW:0]       wr_ptr, rd_ptr;
    logic [AW:0]       fill;
    logic              full, push, pop, drop;
    stream_word_t      head;

    always_comb begin
        fill   = wr_ptr - rd_ptr;
        full   = (fill == (AW+1)'(DEPTH));
        tvalid = (wr_ptr != rd_ptr);
        push   = in_vld && !full;
        drop   = in_vld && full;
        pop    = tvalid && tready;
        head   = mem[rd_ptr[AW-1:0]];
        tdata  = head.data;
        tlast  = head.last;
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr[AW-1:0]] <= in_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            ovf    <= 1'b0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            if (drop)         ovf <= 1'b1;
            else if (ovf_clr) ovf <= 1'b0;
        end
    end

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (tvalid && !tready) |=> (tvalid && $stable(tdata) && $stable(tlast)));

    p_ovf_set_r8: assert property (@(posedge clk) disable iff (rst)
        (in_vld && full) |=> ovf);

    p_full_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (full && !tready) |=> full);

    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (ovf && !ovf_clr) |=> ovf);

    p_ovf_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (ovf_clr && !(in_vld && full)) |=> !ovf);

endmodule

// File: rtl/iqcap_ddr_packer.sv
module iqcap_ddr_packer
    import iqcap_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic [HALF_W-1:0] rx_i,
    input  logic [HALF_W-1:0] rx_q,
    input  logic              ovf_clr,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic [WORD_W-1:0] m_tdata,
    output logic              m_tlast,
    output logic              ovf_flag
);

    iq_pair_t     pair;
    logic         pair_vld;
    stream_word_t word;
    logic         word_vld;

    iqcap_ddr_front u_front (
        .clk      (clk),
        .rst      (rst),
        .rx_i     (rx_i),
        .rx_q     (rx_q),
        .pair     (pair),
        .pair_vld (pair_vld)
    );

    iqcap_packer u_pack (
        .clk      (clk),
        .rst      (rst),
        .en       (cap_en),
        .pair     (pair),
        .pair_vld (pair_vld),
        .word_vld (word_vld),
        .word     (word)
    );

    iqcap_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (word_vld),
        .in_word (word),
        .ovf_clr (ovf_clr),
        .tvalid  (m_tvalid),
        .tready  (m_tready),
        .tdata   (m_tdata),
        .tlast   (m_tlast),
        .ovf     (ovf_flag)
    );

endmodule

// File: tb/iqcap_ddr_packer_tb.sv
module iqcap_ddr_packer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cap_en = 1'b0;
    logic [1:0]  rx_i = '0, rx_q = '0;
    logic        ovf_clr = 1'b0;
    logic        m_tvalid, m_tready = 1'b1, m_tlast, ovf_flag;
    logic [31:0] m_tdata;

    iqcap_ddr_packer #(.FIFO_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .cap_en(cap_en), .rx_i(rx_i), .rx_q(rx_q),
        .ovf_clr(ovf_clr), .m_tvalid(m_tvalid), .m_tready(m_tready),
        .m_tdata(m_tdata), .m_tlast(m_tlast), .ovf_flag(ovf_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_cmp = 0, n_bad = 0, cycles = 0;
    bit finished = 0;

    logic [31:0] exp_data [0:511];
    logic        exp_last [0:511];
    int          exp_n = 0, rx_n = 0;
    logic [31:0] acc_m = '0;
    int          slot_m = 0;
    logic [3:0]  pend_i = '0, pend_q = '0;
    logic        pend_e = 1'b0;
    int          rdy_mode = 0;
    logic [7:0]  lfsr = 8'hA5;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, expv);
        end
    endtask

    task automatic push_exp(input logic [31:0] d, input logic l);
        exp_data[exp_n] = d;
        exp_last[exp_n] = l;
        exp_n++;
    endtask

    // Expected packing: oldest pair in the low byte, {I,Q} per byte (R3/R4/R5/R6).
    task automatic model_pair(input logic [3:0] i, input logic [3:0] q, input logic e);
        if (e) begin
            acc_m = acc_m | ({24'd0, i, q} << (8 * slot_m));
            slot_m++;
            if (slot_m == 4) begin
                push_exp(acc_m, 1'b0);
                acc_m = '0;
                slot_m = 0;
            end
        end else if (slot_m != 0) begin
            push_exp(acc_m, 1'b1);
            acc_m = '0;
            slot_m = 0;
        end
    endtask

    // One forwarded-clock cycle: upper halves before the rising edge,
    // lower halves before the falling edge (R2).
    task automatic send(input logic [3:0] si, input logic [3:0] sq, input logic se);
        @(negedge clk); #1;
        rx_i = si[3:2];
        rx_q = sq[3:2];
        @(posedge clk); #1;
        rx_i = si[1:0];
        rx_q = sq[1:0];
        cap_en = pend_e;
        model_pair(pend_i, pend_q, pend_e);
        pend_i = si; pend_q = sq; pend_e = se;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        case (rdy_mode)
            0: m_tready = 1'b1;
            1: m_tready = lfsr[0] | lfsr[1];
            default: m_tready = 1'b0;
        endcase
    endtask

    task automatic drain(input string tag);
        rdy_mode = 0;
        for (int k = 0; k < 80; k++) send(4'h0, 4'h0, 1'b0);
        check(tag, 64'(rx_n), 64'(exp_n));
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst = 1'b1;
        @(posedge clk); #1;
        @(posedge clk); #1;
        rst = 1'b0;
        cap_en = 1'b0;
        pend_e = 1'b0;
        acc_m = '0;
        slot_m = 0;
        exp_n = rx_n;
    endtask

    // Stream receiver: a transfer happens at the next rising edge.
    always @(negedge clk) begin
        if (!rst && m_tvalid && m_tready) begin
            if (rx_n < exp_n) begin
                check("R3 word data", 64'(m_tdata), 64'(exp_data[rx_n]));
                check("R6 word last", 64'(m_tlast), 64'(exp_last[rx_n]));
            end else begin
                check("R7 unexpected word", 64'(rx_n), 64'(exp_n));
            end
            rx_n++;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R1 reset tvalid", 64'(m_tvalid), 64'd0);
        check("R1 reset ovf", 64'(ovf_flag), 64'd0);
        for (int k = 0; k < 3; k++) send(4'h0, 4'h0, 1'b0);

        // R2 R3 R4: two full words with distinct nibbles
        for (int k = 0; k < 8; k++) send(4'(k + 1), 4'(15 - k), 1'b1);
        drain("R4 two full words");

        // R7: all 256 pair values under pseudo-random back-pressure
        rdy_mode = 1;
        for (int v = 0; v < 256; v++) send(v[7:4], v[3:0], 1'b1);
        drain("R7 sweep count");
        check("R7 no overflow at 75% ready", 64'(ovf_flag), 64'd0);

        // R6: every run length 1..7, each ended by one idle cycle
        for (int len = 1; len < 8; len++) begin
            for (int k = 0; k < len; k++) send(4'(len), 4'(k), 1'b1);
            send(4'h0, 4'h0, 1'b0);
        end
        drain("R6 partial flush count");

        // R5: enable gaps mid-stream restart at slot 0
        for (int k = 0; k < 60; k++) send(4'(k), 4'(k * 3), (k % 7) != 3);
        drain("R5 gap pattern count");

        // R8: overflow with ready held low
        rdy_mode = 2;
        for (int k = 0; k < 100; k++) send(4'(k * 5), 4'(k), 1'b1);
        for (int k = 0; k < 4; k++) send(4'h0, 4'h0, 1'b0);
        @(negedge clk);
        check("R8 overflow flag set", 64'(ovf_flag), 64'd1);
        check("R8 fifo holds data", 64'(m_tvalid), 64'd1);
        begin
            int base;
            base = rx_n;
            rdy_mode = 0;
            for (int k = 0; k < 60; k++) send(4'h0, 4'h0, 1'b0);
            check("R8 kept words", 64'(rx_n - base), 64'(DEPTH));
            exp_n = rx_n;
        end
        check("R9 flag sticky", 64'(ovf_flag), 64'd1);

        // R9: clear pulse
        @(posedge clk); #1 ovf_clr = 1'b1;
        @(posedge clk); #1 ovf_clr = 1'b0;
        @(negedge clk);
        check("R9 flag cleared", 64'(ovf_flag), 64'd0);

        // R1: reset with words waiting in the FIFO
        rdy_mode = 2;
        for (int k = 0; k < 12; k++) send(4'(k), 4'(k), 1'b1);
        for (int k = 0; k < 4; k++) send(4'h0, 4'h0, 1'b0);
        @(negedge clk);
        check("R1 fifo loaded before reset", 64'(m_tvalid), 64'd1);
        do_reset();
        @(negedge clk);
        check("R1 fifo empty after reset", 64'(m_tvalid), 64'd0);
        check("R1 ovf clear after reset", 64'(ovf_flag), 64'd0);
        for (int k = 0; k < 3; k++) send(4'h0, 4'h0, 1'b0);

        // R1: slot back at 0 after reset
        for (int k = 0; k < 4; k++) send(4'hC, 4'(k), 1'b1);
        drain("R1 clean word after reset");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule